// File: doc/BRIEF.md
# Calibrated Temperature Conversion Datapath

This block turns raw thermal-sensor codes into signed temperatures in millidegrees Celsius. A calibration record supplies an ADC gain error, one code offset per sensor, a reference temperature, a six-bit slope correction with a sign bit and an identification bit, and a chip-wide slope constant. From these the block derives one scale factor. It does this by dividing a fixed numerator twice with truncation on a shared iterative divider. After that, each sample needs only one signed multiply, an arithmetic shift and a subtraction.

Samples arrive on a valid/ready handshake as a sensor index, a raw code and a group-end flag. Every accepted sample produces a one-cycle done pulse carrying the sensor index and the temperature. Readings above the plausibility ceiling are forced to zero. A running maximum over the samples of a group is reported when the sample flagged as group end completes. When the record is marked invalid, fixed default calibration values replace every field.

The controller has five states. ST_LOAD latches the effective calibration and starts the first division. ST_SCALE1 waits for that quotient and starts the second division. ST_SCALE2 waits for the scale factor. ST_READY accepts samples or a calibration reload. ST_CONV produces one result. The transitions are:
- ST_LOAD to ST_SCALE1, always.
- ST_SCALE1 to ST_SCALE2, on divider done.
- ST_SCALE2 to ST_READY, on divider done.
- ST_READY to ST_LOAD, on a reload request.
- ST_READY to ST_CONV, on a sample.
- ST_CONV to ST_READY, always.

Reset enters ST_LOAD.

Top module: `tsense_conv`

## Requirements
- R1: Only the low 12 bits of `s_raw` enter the conversion; bits 15..12 have no effect on the result.
- R2: The scale factor equals trunc(trunc(1627604160 / (slope_k + slope)) / (10000 + gain)). It is recomputed after reset and after each `cal_load`, and `s_ready` stays low while that happens.
- R3: The temperature is tref*500 - ((scale * (code - offset[s_sensor] - 3350)) >>> 3), using 32-bit signed arithmetic with a flooring shift. The offset of sensor i sits in `cal_offs[9*i+8:9*i]`.
- R4: A temperature above 200000 is reported as 0.
- R5: The slope correction is the 6-bit magnitude `cal_smag`. It is negated only when both `cal_ssgn` and `cal_id` are 1.
- R6: When `cal_ok` is 0, the block uses gain 512, every offset 260, tref 40 and slope 0, whatever the other fields hold.
- R7: Changes to the calibration inputs have no effect until a `cal_load` is accepted in ST_READY.
- R8: A sample is taken on a cycle with `s_valid` and `s_ready` both high. `s_ready` is low on the next cycle. `t_done` is high for exactly one cycle, two clock edges after acceptance, with `t_sensor` equal to the index.
- R9: The group maximum starts from the most negative 32-bit value and includes clamped results. With the result of a sample that had `s_last` set, `grp_done` pulses, `grp_max` shows the maximum, and the next group starts afresh.
- R10: During reset, `s_ready`, `t_done` and `grp_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cal_load | input | 1 | Reload calibration and recompute scale |
| cal_ok | input | 1 | Calibration record valid |
| cal_gain | input | 10 | ADC gain error |
| cal_offs | input | 54 | Per-sensor code offsets, 9 bits each |
| cal_tref | input | 6 | Reference temperature |
| cal_smag | input | 6 | Slope correction magnitude |
| cal_ssgn | input | 1 | Slope sign bit |
| cal_id | input | 1 | Identification bit gating the sign |
| slope_k | input | 8 | Chip slope constant (165 or 153) |
| s_valid | input | 1 | Sample valid |
| s_ready | output | 1 | Sample accepted when high |
| s_sensor | input | 3 | Sensor index |
| s_raw | input | 16 | Raw code |
| s_last | input | 1 | Last sample of a group |
| t_done | output | 1 | Result pulse |
| t_sensor | output | 3 | Index of the result |
| t_milli | output | 32 | Signed temperature, millidegrees |
| grp_done | output | 1 | Group maximum valid |
| grp_max | output | 32 | Signed group maximum |

## Verification
Some behaviours are checked by assertions on every cycle:
- each divider result satisfies quotient times divisor plus remainder equals dividend, with the remainder below the divisor;
- the ready line stays low while the divider is busy;
- an accepted sample yields done two edges later;
- no reported temperature exceeds the ceiling;
- a group maximum is never below the result that closes its group.

The bench scenarios cover the rest. These are the exact temperature values, the masking of high code bits, default substitution for an invalid record, the slope sign rule, the alternate slope constant, and calibration changes being ignored until a reload.

// File: rtl/tsense_pkg.sv
package tsense_pkg;
    localparam int DW = 32;
    localparam logic [31:0] SCALE_NUM = 32'd1627604160;
    localparam logic signed [31:0] CODE_BIAS = 32'sd3350;
    localparam logic signed [31:0] TEMP_CEIL = 32'sd200000;
    localparam logic signed [31:0] TEMP_FLOOR = 32'sh8000_0000;
    localparam logic signed [31:0] TREF_MULT = 32'sd500;
    localparam logic [31:0] GE_BASE = 32'd10000;
    localparam int DEF_GE = 512;
    localparam int DEF_VTS = 260;
    localparam int DEF_TREF = 40;

    typedef enum logic [2:0] {
        ST_LOAD,
        ST_SCALE1,
        ST_SCALE2,
        ST_READY,
        ST_CONV
    } conv_state_t;
endpackage

// File: rtl/tsense_calsel.sv
module tsense_calsel #(
    parameter int NSENS = 6,
    parameter int VW = 9,
    parameter int GW = 10,
    parameter int TW = 6,
    parameter int MW = 6
) (
    input  logic                    cal_ok,
    input  logic [GW-1:0]           gain_in,
    input  logic [NSENS*VW-1:0]     offs_in,
    input  logic [TW-1:0]           tref_in,
    input  logic [MW-1:0]           smag,
    input  logic                    ssgn,
    input  logic                    id_bit,
    output logic [GW-1:0]           gain_eff,
    output logic [NSENS*VW-1:0]     offs_eff,
    output logic [TW-1:0]           tref_eff,
    output logic signed [31:0]      slope_eff
);
    import tsense_pkg::*;

    assign gain_eff = cal_ok ? gain_in : GW'(DEF_GE);
    assign tref_eff = cal_ok ? tref_in : TW'(DEF_TREF);

    for (genvar g = 0; g < NSENS; g++) begin : g_offs
        assign offs_eff[g*VW +: VW] = cal_ok ? offs_in[g*VW +: VW] : VW'(DEF_VTS);
    end

    logic signed [31:0] mag_ext;
    assign mag_ext = $signed({{(32-MW){1'b0}}, smag});

    always_comb begin
        if (!cal_ok)
            slope_eff = '0;
        else if (ssgn && id_bit)
            slope_eff = -mag_ext;
        else
            slope_eff = mag_ext;
    end
endmodule

// File: rtl/tsense_divider.sv
module tsense_divider #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dvd,
    input  logic [W-1:0] dsr,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quo
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  acc;
    logic [W-1:0]  q;
    logic [W-1:0]  dvd_q;
    logic [W-1:0]  dsr_q;
    logic [CW-1:0] cnt;
    logic [W:0]    shifted;
    logic [W:0]    trial;

    assign shifted = {acc, q[W-1]};
    assign trial   = shifted - {1'b0, dsr_q};
    assign quo     = q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc   <= '0;
            q     <= '0;
            dvd_q <= '0;
            dsr_q <= '0;
            cnt   <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
        end else if (start) begin
            acc   <= '0;
            q     <= dvd;
            dvd_q <= dvd;
            dsr_q <= dsr;
            cnt   <= CW'(W);
            busy  <= 1'b1;
            done  <= 1'b0;
        end else if (busy) begin
            if (!trial[W]) begin
                acc <= trial[W-1:0];
                q   <= {q[W-2:0], 1'b1};
            end else begin
                acc <= shifted[W-1:0];
                q   <= {q[W-2:0], 1'b0};
            end
            cnt  <= cnt - 1'b1;
            busy <= (cnt != CW'(1));
            done <= (cnt == CW'(1));
        end else begin
            done <= 1'b0;
        end
    end

    // R2: each quotient is exact truncating division
    p_div_exact_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (({{W{1'b0}}, q} * {{W{1'b0}}, dsr_q} + {{W{1'b0}}, acc}
                   == {{W{1'b0}}, dvd_q}) && (acc < dsr_q)));
endmodule

// File: rtl/tsense_conv.sv
module tsense_conv #(
    parameter int NSENS = 6,
    parameter int VW = 9,
    parameter int GW = 10,
    parameter int TW = 6,
    parameter int MW = 6,
    parameter int KW = 8,
    parameter int RW = 16,
    parameter int CW = 12,
    localparam int IW = (NSENS > 1) ? $clog2(NSENS) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cal_load,
    input  logic                     cal_ok,
    input  logic [GW-1:0]            cal_gain,
    input  logic [NSENS*VW-1:0]      cal_offs,
    input  logic [TW-1:0]            cal_tref,
    input  logic [MW-1:0]            cal_smag,
    input  logic                     cal_ssgn,
    input  logic                     cal_id,
    input  logic [KW-1:0]            slope_k,
    input  logic                     s_valid,
    output logic                     s_ready,
    input  logic [IW-1:0]            s_sensor,
    input  logic [RW-1:0]            s_raw,
    input  logic                     s_last,
    output logic                     t_done,
    output logic [IW-1:0]            t_sensor,
    output logic signed [31:0]       t_milli,
    output logic                     grp_done,
    output logic signed [31:0]       grp_max
);
    import tsense_pkg::*;

    conv_state_t state, state_nx;

    logic [GW-1:0]        ge_eff;
    logic [NSENS*VW-1:0]  offs_eff;
    logic [TW-1:0]        tref_eff;
    logic signed [31:0]   slope_eff;

    logic [GW-1:0]        ge_q;
    logic [VW-1:0]        vts_q [NSENS];
    logic [TW-1:0]        tref_q;
    logic signed [31:0]   scale_q;
    logic signed [31:0]   diff_q;
    logic [IW-1:0]        idx_q;
    logic                 last_q;
    logic signed [31:0]   grp_run;

    logic                 dv_start, dv_busy, dv_done;
    logic [31:0]          dv_dvd, dv_dsr, dv_quo;

    logic [VW-1:0]        vts_sel;
    logic signed [31:0]   diff_new, prod, temp, clamped, newmax;
    logic                 raw_hi_unused;

    assign raw_hi_unused = ^s_raw[RW-1:CW];

    tsense_calsel #(.NSENS(NSENS), .VW(VW), .GW(GW), .TW(TW), .MW(MW)) u_calsel (
        .cal_ok(cal_ok), .gain_in(cal_gain), .offs_in(cal_offs), .tref_in(cal_tref),
        .smag(cal_smag), .ssgn(cal_ssgn), .id_bit(cal_id),
        .gain_eff(ge_eff), .offs_eff(offs_eff), .tref_eff(tref_eff), .slope_eff(slope_eff)
    );

    tsense_divider #(.W(DW)) u_div (
        .clk(clk), .rst_n(rst_n), .start(dv_start), .dvd(dv_dvd), .dsr(dv_dsr),
        .busy(dv_busy), .done(dv_done), .quo(dv_quo)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_LOAD;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_LOAD:   state_nx = ST_SCALE1;
            ST_SCALE1: if (dv_done) state_nx = ST_SCALE2;
            ST_SCALE2: if (dv_done) state_nx = ST_READY;
            ST_READY:  if (cal_load) state_nx = ST_LOAD;
                       else if (s_valid) state_nx = ST_CONV;
            ST_CONV:   state_nx = ST_READY;
            default:   state_nx = ST_LOAD;
        endcase
    end

    // control outputs
    always_comb begin
        s_ready  = (state == ST_READY) && !cal_load;
        dv_start = (state == ST_LOAD) || ((state == ST_SCALE1) && dv_done);
        if (state == ST_LOAD) begin
            dv_dvd = SCALE_NUM;
            dv_dsr = {{(DW-KW){1'b0}}, slope_k} + $unsigned(slope_eff);
        end else begin
            dv_dvd = dv_quo;
            dv_dsr = GE_BASE + {{(DW-GW){1'b0}}, ge_q};
        end
    end

    // conversion arithmetic
    always_comb begin
        vts_sel = '0;
        for (int i = 0; i < NSENS; i++)
            if (s_sensor == IW'(i)) vts_sel = vts_q[i];
        diff_new = $signed({{(DW-CW){1'b0}}, s_raw[CW-1:0]})
                 - $signed({{(DW-VW){1'b0}}, vts_sel}) - CODE_BIAS;
        prod     = scale_q * diff_q;
        temp     = $signed({{(DW-TW){1'b0}}, tref_q}) * TREF_MULT - (prod >>> 3);
        clamped  = (temp > TEMP_CEIL) ? 32'sd0 : temp;
        newmax   = (clamped > grp_run) ? clamped : grp_run;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ge_q     <= '0;
            tref_q   <= '0;
            for (int i = 0; i < NSENS; i++) vts_q[i] <= '0;
            scale_q  <= '0;
            diff_q   <= '0;
            idx_q    <= '0;
            last_q   <= 1'b0;
            grp_run  <= TEMP_FLOOR;
            t_done   <= 1'b0;
            t_sensor <= '0;
            t_milli  <= '0;
            grp_done <= 1'b0;
            grp_max  <= '0;
        end else begin
            t_done   <= 1'b0;
            grp_done <= 1'b0;
            unique case (state)
                ST_LOAD: begin
                    ge_q   <= ge_eff;
                    tref_q <= tref_eff;
                    for (int i = 0; i < NSENS; i++) vts_q[i] <= offs_eff[i*VW +: VW];
                end
                ST_SCALE2: if (dv_done) scale_q <= $signed(dv_quo);
                ST_READY: if (s_valid && s_ready) begin
                    diff_q <= diff_new;
                    idx_q  <= s_sensor;
                    last_q <= s_last;
                end
                ST_CONV: begin
                    t_done   <= 1'b1;
                    t_sensor <= idx_q;
                    t_milli  <= clamped;
                    if (last_q) begin
                        grp_max  <= newmax;
                        grp_done <= 1'b1;
                        grp_run  <= TEMP_FLOOR;
                    end else begin
                        grp_run  <= newmax;
                    end
                end
                default: ;
            endcase
        end
    end

    p_busy_noready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dv_busy |-> !s_ready);
    p_done_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready) |-> ##2 t_done);
    p_ready_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready) |=> !s_ready);
    p_ceiling_r4: assert property (@(posedge clk) disable iff (!rst_n)
        t_done |-> (t_milli <= TEMP_CEIL));
    p_grp_ge_r9: assert property (@(posedge clk) disable iff (!rst_n)
        grp_done |-> (t_done && (grp_max >= t_milli)));
endmodule

// File: tb/tsense_conv_test.sv
module tsense_conv_test;
    typedef struct packed {
        logic [15:0]        raw;
        logic [2:0]         idx;
        logic               last;
        logic signed [31:0] exp_t;
        logic signed [31:0] exp_g;
    } vec_t;

    // default calibration (record invalid), slope constant 165
    localparam vec_t VEC [8] = '{
        '{16'd3000,  3'd0, 1'b0,  32'sd91523,  32'sd0},
        '{16'd3610,  3'd1, 1'b0,  32'sd20000,  32'sd0},
        '{16'h1E74,  3'd2, 1'b1,  32'sd9448,   32'sd91523},
        '{16'd4095,  3'd3, 1'b0, -32'sd36866,  32'sd0},
        '{16'd2000,  3'd4, 1'b1,  32'sd0,      32'sd0},
        '{16'd2500,  3'd5, 1'b0,  32'sd150148, 32'sd0},
        '{16'd4095,  3'd0, 1'b1, -32'sd36866,  32'sd150148},
        '{16'd4095,  3'd1, 1'b1, -32'sd36866, -32'sd36866}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cal_load = 1'b0;
    logic cal_ok = 1'b0;
    logic [9:0] cal_gain = 10'h3FF;
    logic [53:0] cal_offs = '1;
    logic [5:0] cal_tref = 6'h3F;
    logic [5:0] cal_smag = 6'h3F;
    logic cal_ssgn = 1'b1;
    logic cal_id = 1'b1;
    logic [7:0] slope_k = 8'd165;
    logic s_valid = 1'b0;
    logic s_ready;
    logic [2:0] s_sensor = '0;
    logic [15:0] s_raw = '0;
    logic s_last = 1'b0;
    logic t_done;
    logic [2:0] t_sensor;
    logic signed [31:0] t_milli;
    logic grp_done;
    logic signed [31:0] grp_max;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    tsense_conv uut (
        .clk(clk), .rst_n(rst_n), .cal_load(cal_load), .cal_ok(cal_ok),
        .cal_gain(cal_gain), .cal_offs(cal_offs), .cal_tref(cal_tref),
        .cal_smag(cal_smag), .cal_ssgn(cal_ssgn), .cal_id(cal_id), .slope_k(slope_k),
        .s_valid(s_valid), .s_ready(s_ready), .s_sensor(s_sensor), .s_raw(s_raw),
        .s_last(s_last), .t_done(t_done), .t_sensor(t_sensor), .t_milli(t_milli),
        .grp_done(grp_done), .grp_max(grp_max)
    );

    task automatic chk(input string req, input logic signed [31:0] act,
                       input logic signed [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    logic signed [31:0] got_t, got_g;
    logic got_done, got_gdone;
    logic [2:0] got_sens;

    task automatic send(input logic [15:0] raw, input logic [2:0] idx, input logic last);
        while (!s_ready) @(negedge clk);
        s_valid = 1'b1; s_raw = raw; s_sensor = idx; s_last = last;
        @(negedge clk);
        s_valid = 1'b0;
        chk("R8 ready low after accept", 32'(s_ready), 0);
        chk("R8 no early done", 32'(t_done), 0);
        @(negedge clk);
        got_t = t_milli; got_g = grp_max; got_done = t_done;
        got_gdone = grp_done; got_sens = t_sensor;
        chk("R8 done pulse", 32'(got_done), 1);
        chk("R8 sensor index", 32'(got_sens), 32'(idx));
        @(negedge clk);
        chk("R8 done one cycle", 32'(t_done), 0);
    endtask

    task automatic reload();
        while (!s_ready) @(negedge clk);
        cal_load = 1'b1;
        @(negedge clk);
        cal_load = 1'b0;
        chk("R2 ready low during scale", 32'(s_ready), 0);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 reset ready", 32'(s_ready), 0);
        chk("R10 reset done", 32'(t_done), 0);
        chk("R10 reset grp_done", 32'(grp_done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 ready low after reset", 32'(s_ready), 0);

        // R6 defaults with garbage fields; R1 masking in entry 2; R3, R4, R9
        foreach (VEC[i]) begin
            send(VEC[i].raw, VEC[i].idx, VEC[i].last);
            chk($sformatf("R3 R6 vector %0d temp", i), got_t, VEC[i].exp_t);
            chk($sformatf("R9 vector %0d grp_done", i), 32'(got_gdone), 32'(VEC[i].last));
            if (VEC[i].last)
                chk($sformatf("R9 vector %0d grp_max", i), got_g, VEC[i].exp_g);
        end

        // R5: valid record, sign and id both set -> slope -10
        cal_ok = 1'b1; cal_gain = 10'd100; cal_offs = {6{9'd300}};
        cal_tref = 6'd45; cal_smag = 6'd10; cal_ssgn = 1'b1; cal_id = 1'b1;
        reload();
        send(16'd3000, 3'd2, 1'b1);
        chk("R5 negated slope", got_t, 32'sd106919);

        // R7: change inputs without reload -> same result
        cal_id = 1'b0; cal_tref = 6'd0; cal_gain = 10'd0;
        send(16'd3000, 3'd2, 1'b1);
        chk("R7 inputs ignored without load", got_t, 32'sd106919);

        // R5: id clear -> slope +10
        cal_tref = 6'd45; cal_gain = 10'd100;
        reload();
        send(16'd3000, 3'd2, 1'b1);
        chk("R5 positive slope when id clear", got_t, 32'sd97250);

        // R2: alternate slope constant with defaults
        cal_ok = 1'b0; slope_k = 8'd153;
        reload();
        send(16'd3000, 3'd4, 1'b1);
        chk("R2 slope constant 153", got_t, 32'sd97089);

        // R1: upper code bits ignored
        send(16'hF000 | 16'd3000, 3'd4, 1'b1);
        chk("R1 high bits masked", got_t, 32'sd97089);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule